// File: doc/BRIEF.md
# Scan test sequencer

This block applies a stored set of scan patterns to a full-scan circuit through one scan chain. It drives the chain's scan-enable and clock-enable, the serial scan-in bit and the primary-input vector. It runs every test as a shift-in, then one capture cycle in normal mode, then a shift-out. Each shift-out overlaps the shift-in of the next pattern. The bits that come back are compared with the expected response. Response positions can be masked as don't-care, and the primary outputs are checked in each capture cycle.

Patterns come from an external memory with a synchronous read port: one word per pattern, with one cycle from address to data. A session starts with a start pulse. Its length is fixed by the chain length L and the pattern count N. It takes exactly (N+2)·L + N + 4 cycles, which is the cycle count behind the test time (cycles × scan clock period):

- 1 setup cycle
- 1 pattern-load cycle
- L cycles of chain clearing
- L + 1 cycles per pattern
- L flush cycles
- 1 verdict cycle
- 1 end cycle

A sticky fail flag and the index of the first failing pattern are kept until reset.

Top module: `scan_test_seq`

## Requirements
- R1: After reset, busy, done, scanEn, chainEn and failFlag are all 0.
- R2: A start pulse taken in idle makes busy high for exactly (N+2)·L + N + 4 consecutive cycles. done is high only in the last of them, and busy is low in the cycle after.
- R3: In each session there are exactly N capture cycles (chainEn=1, scanEn=0). Counting the first busy cycle as 0, pattern k is captured in cycle 2 + L + k·(L+1) + L. Every other cycle with chainEn=1 has scanEn=1.
- R4: Pattern word layout, from LSB:
  - bits [L-1:0]: stimulus
  - bits [2L-1:L]: expected response
  - bits [3L-1:2L]: mask
  - next PI_W bits: primary-input vector
  - top PO_W bits: expected primary outputs

  Cell 0 is next to scanIn and cell L-1 drives scanOut. Stimulus bit L-1 is shifted first, so at capture each cell i holds stimulus bit i.
- R5: During the capture cycle of pattern k, piVec equals that pattern's primary-input field. poVec is compared with its expected-output field at that cycle's clock edge.
- R6: The captured response of pattern k is compared during the shift-in of pattern k+1, with cell L-1 first. The response of the last pattern is compared during a final flush shift. No compare runs during the first shift-in. scanIn is 0 during the L clearing cycles and the L flush cycles.
- R7: A response bit whose mask bit is 0 is never compared; a mismatch there leaves failFlag at 0.
- R8: The first mismatch sets failFlag. failVec takes the index of the pattern whose response or output mismatched. Both hold, even across later mismatches and later sessions, until reset.
- R9: A start pulse while busy is ignored; the session length is unchanged.
- R10: memAddr is 0 in the first busy cycle and k+1 while pattern k is shifted and captured. Data is used one cycle after its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a session when idle |
| memAddr | output | VEC_W | Pattern memory read address |
| memData | input | WORD_W | Pattern word, one cycle after its address |
| scanEn | output | 1 | Scan mode select for the chain (1 = shift) |
| chainEn | output | 1 | Clock enable for the scan cells |
| scanIn | output | 1 | Serial data into cell 0 |
| scanOut | input | 1 | Serial data from cell L-1 |
| piVec | output | PI_W | Primary-input vector |
| poVec | input | PO_W | Primary outputs of the circuit |
| busy | output | 1 | Session in progress |
| done | output | 1 | Last cycle of a session |
| failFlag | output | 1 | Sticky mismatch flag |
| failVec | output | VEC_W | Index of the first failing pattern |

## Verification
The hardest cases are an error met only in the flush shift and the first-error-wins rule. For the flush case, only the last pattern's response is corrupted at cell 0, so the error appears in the very last flush cycle. For the second case, a primary-output error on one pattern is combined with a later scan-response error. Other sessions corrupt a masked-out bit and the first pattern's response, which is checked during the second pattern's shift. A scan-chain model in the bench applies a fixed logic function, and the expected responses are computed from it for each session's arithmetic pattern set. A second start pulse in mid-session tests that the cycle count is held.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_LOAD, ST_CLEAR, ST_SHIFT,
    ST_CAPT, ST_FLUSH, ST_CHECK, ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPat;   // take memory word into the current pattern register
    logic drivePat;  // drive stimulus bits onto scanIn
    logic cmpScan;   // compare scanOut with the held response
    logic cmpPo;     // capture cycle: compare primary outputs, keep response
  } seqStrobe_t;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int NUM_VEC   = 4,
  parameter int BIT_W     = 3,
  parameter int VEC_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output seqStrobe_t       str,
  output logic [BIT_W-1:0] bitIdx,
  output logic [VEC_W-1:0] respIdx,
  output logic [VEC_W-1:0] memAddr,
  output logic             scanEn,
  output logic             chainEn,
  output logic             busy,
  output logic             done
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAIN_LEN - 1);
  localparam logic [VEC_W-1:0] LAST_VEC = VEC_W'(NUM_VEC - 1);
  localparam int SESSION_CYCLES = (NUM_VEC + 2) * CHAIN_LEN + NUM_VEC + 4;

  seqState_t        state;
  logic [BIT_W-1:0] bitCnt;
  logic [VEC_W-1:0] vecCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      vecCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SETUP;
            vecCnt <= '0;
          end
        end
        ST_SETUP: state <= ST_LOAD;
        ST_LOAD: begin
          state  <= ST_CLEAR;
          bitCnt <= LAST_BIT;
        end
        ST_CLEAR: begin
          if (bitCnt == '0) begin
            state  <= ST_SHIFT;
            bitCnt <= LAST_BIT;
          end else begin
            bitCnt <= bitCnt - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (bitCnt == '0) state <= ST_CAPT;
          else bitCnt <= bitCnt - 1'b1;
        end
        ST_CAPT: begin
          bitCnt <= LAST_BIT;
          if (vecCnt == LAST_VEC) begin
            state <= ST_FLUSH;
          end else begin
            state  <= ST_SHIFT;
            vecCnt <= vecCnt + 1'b1;
          end
        end
        ST_FLUSH: begin
          if (bitCnt == '0) state <= ST_CHECK;
          else bitCnt <= bitCnt - 1'b1;
        end
        ST_CHECK: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    str.loadPat  = (state == ST_LOAD) || (state == ST_CAPT);
    str.drivePat = (state == ST_SHIFT);
    str.cmpScan  = ((state == ST_SHIFT) && (vecCnt != '0)) || (state == ST_FLUSH);
    str.cmpPo    = (state == ST_CAPT);
  end

  assign bitIdx  = bitCnt;
  // during a shift the response coming out belongs to the previous pattern
  assign respIdx = (state == ST_SHIFT) ? vecCnt - 1'b1 : vecCnt;
  // the next pattern is addressed early so its word is ready at capture
  assign memAddr = (state == ST_SETUP) ? '0 : vecCnt + 1'b1;
  assign scanEn  = (state == ST_CLEAR) || (state == ST_SHIFT) || (state == ST_FLUSH);
  assign chainEn = scanEn || (state == ST_CAPT);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);

  // session length checker
  logic [31:0] sessLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sessLen <= '0;
    else if (state == ST_IDLE) sessLen <= '0;
    else sessLen <= sessLen + 1;
  end

  p_session_length_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sessLen == 32'(SESSION_CYCLES - 1)));

  p_done_then_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  p_capture_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chainEn && !scanEn) |=> (chainEn && scanEn));

endmodule

// File: rtl/scan_seq_dpath.sv
module scan_seq_dpath
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int NUM_VEC   = 4,
  parameter int PI_W      = 4,
  parameter int PO_W      = 2,
  parameter int BIT_W     = 3,
  parameter int VEC_W     = 3,
  parameter int WORD_W    = 3 * 8 + 4 + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        str,
  input  logic [BIT_W-1:0]  bitIdx,
  input  logic [VEC_W-1:0]  respIdx,
  input  logic [WORD_W-1:0] memData,
  input  logic              scanOut,
  input  logic [PO_W-1:0]   poVec,
  output logic              scanIn,
  output logic [PI_W-1:0]   piVec,
  output logic              failFlag,
  output logic [VEC_W-1:0]  failVec
);

  localparam int STIM_LO = 0;
  localparam int RESP_LO = CHAIN_LEN;
  localparam int MASK_LO = 2 * CHAIN_LEN;
  localparam int PI_LO   = 3 * CHAIN_LEN;
  localparam int PO_LO   = 3 * CHAIN_LEN + PI_W;

  logic [WORD_W-1:0]    curPat;
  logic [CHAIN_LEN-1:0] prevResp, prevMask;
  logic [CHAIN_LEN-1:0] curStim, curResp, curMask;
  logic [PO_W-1:0]      curExpPo;
  logic                 scanMiss, poMiss;

  assign curStim  = curPat[STIM_LO +: CHAIN_LEN];
  assign curResp  = curPat[RESP_LO +: CHAIN_LEN];
  assign curMask  = curPat[MASK_LO +: CHAIN_LEN];
  assign piVec    = curPat[PI_LO +: PI_W];
  assign curExpPo = curPat[PO_LO +: PO_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPat   <= '0;
      prevResp <= '0;
      prevMask <= '0;
    end else begin
      if (str.cmpPo) begin
        prevResp <= curResp;
        prevMask <= curMask;
      end
      if (str.loadPat) curPat <= memData;
    end
  end

  assign scanIn   = str.drivePat & curStim[bitIdx];
  assign scanMiss = str.cmpScan & prevMask[bitIdx] & (scanOut ^ prevResp[bitIdx]);
  assign poMiss   = str.cmpPo & (poVec != curExpPo);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failFlag <= 1'b0;
      failVec  <= '0;
    end else if (!failFlag && (scanMiss || poMiss)) begin
      failFlag <= 1'b1;
      failVec  <= respIdx;
    end
  end

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |=> failFlag);

  p_fail_index_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |=> $stable(failVec));

  p_fail_index_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |-> (failVec < VEC_W'(NUM_VEC)));

  p_masked_no_fail_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!failFlag && str.cmpScan && !prevMask[bitIdx]) |=> !failFlag);

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int NUM_VEC   = 4,
  parameter int PI_W      = 4,
  parameter int PO_W      = 2,
  localparam int BIT_W    = $clog2(CHAIN_LEN),
  localparam int VEC_W    = $clog2(NUM_VEC + 1),
  localparam int WORD_W   = 3 * CHAIN_LEN + PI_W + PO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [VEC_W-1:0]  memAddr,
  input  logic [WORD_W-1:0] memData,
  output logic              scanEn,
  output logic              chainEn,
  output logic              scanIn,
  input  logic              scanOut,
  output logic [PI_W-1:0]   piVec,
  input  logic [PO_W-1:0]   poVec,
  output logic              busy,
  output logic              done,
  output logic              failFlag,
  output logic [VEC_W-1:0]  failVec
);

  seqStrobe_t       str;
  logic [BIT_W-1:0] bitIdx;
  logic [VEC_W-1:0] respIdx;

  scan_seq_ctrl #(
    .CHAIN_LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC), .BIT_W(BIT_W), .VEC_W(VEC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .str(str), .bitIdx(bitIdx),
    .respIdx(respIdx), .memAddr(memAddr), .scanEn(scanEn), .chainEn(chainEn),
    .busy(busy), .done(done)
  );

  scan_seq_dpath #(
    .CHAIN_LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC), .PI_W(PI_W), .PO_W(PO_W),
    .BIT_W(BIT_W), .VEC_W(VEC_W), .WORD_W(WORD_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .str(str), .bitIdx(bitIdx), .respIdx(respIdx),
    .memData(memData), .scanOut(scanOut), .poVec(poVec), .scanIn(scanIn),
    .piVec(piVec), .failFlag(failFlag), .failVec(failVec)
  );

endmodule

// File: tb/tb_scan_test_seq.sv
`timescale 1ns/100ps
module tb_scan_test_seq;

  localparam int L     = 4;
  localparam int N     = 5;
  localparam int PIW   = 3;
  localparam int POW   = 2;
  localparam int VW    = $clog2(N + 1);
  localparam int WW    = 3 * L + PIW + POW;
  localparam int TOTAL = (N + 2) * L + N + 4;
  localparam int FLUSH_LO = 2 + L + N * (L + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [VW-1:0]  memAddr;
  logic [WW-1:0]  memData;
  logic scanEn, chainEn, scanIn, scanOut, busy, done, failFlag;
  logic [PIW-1:0] piVec;
  logic [POW-1:0] poVec;
  logic [VW-1:0]  failVec;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [L-1:0]   stimA [0:N];
  logic [L-1:0]   respA [0:N];
  logic [L-1:0]   maskA [0:N];
  logic [PIW-1:0] piA   [0:N];
  logic [POW-1:0] poA   [0:N];

  logic [L-1:0] chain;

  always #2.5 clk = ~clk;

  scan_test_seq #(.CHAIN_LEN(L), .NUM_VEC(N), .PI_W(PIW), .PO_W(POW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .memAddr(memAddr), .memData(memData),
    .scanEn(scanEn), .chainEn(chainEn), .scanIn(scanIn), .scanOut(scanOut),
    .piVec(piVec), .poVec(poVec), .busy(busy), .done(done),
    .failFlag(failFlag), .failVec(failVec)
  );

  function automatic logic [L-1:0] captOf(input logic [L-1:0] s, input logic [PIW-1:0] p);
    logic [L-1:0] r;
    for (int i = 0; i < L; i++) r[i] = s[(i + 1) % L] ^ p[i % PIW];
    return r;
  endfunction

  function automatic logic [POW-1:0] poOf(input logic [L-1:0] s, input logic [PIW-1:0] p);
    return {(^s) ^ p[0], s[0] & p[1]};
  endfunction

  // circuit under test: scan chain plus combinational logic
  always @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= 4'b1011;
    else if (chainEn) begin
      if (scanEn) chain <= {chain[L-2:0], scanIn};
      else chain <= captOf(chain, piVec);
    end
  end
  assign scanOut = chain[L-1];
  assign poVec   = poOf(chain, piVec);

  // synchronous-read pattern memory
  always @(posedge clk) begin
    if (int'(memAddr) <= N)
      memData <= {poA[memAddr], piA[memAddr], maskA[memAddr], respA[memAddr], stimA[memAddr]};
    else
      memData <= '0;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic buildSet(input int seed);
    for (int k = 0; k <= N; k++) begin
      stimA[k] = L'((k * 11 + seed * 7 + 5) & 15);
      piA[k]   = PIW'((k * 5 + seed) & 7);
      maskA[k] = '1;
      respA[k] = captOf(stimA[k], piA[k]);
      poA[k]   = poOf(stimA[k], piA[k]);
    end
    stimA[N] = '0; piA[N] = '0; maskA[N] = '0; respA[N] = '0; poA[N] = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    start = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !scanEn && !chainEn && !failFlag, "R1 reset state",
          {busy, done, scanEn, chainEn, failFlag}, 0);
  endtask

  task automatic runSession(input bit midStart, input string name);
    int c = 0;
    int capIdx = 0;
    int doneCnt = 0;
    int doneAt = -1;
    int quietBad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && memAddr == 0, "R10 first busy cycle addresses pattern 0", memAddr, 0);
    while (busy && c < TOTAL + 20) begin
      if (midStart) start = (c == 10);
      if (done) begin doneCnt++; doneAt = c; end
      if (chainEn && !scanEn) begin
        check(c == 2 + L + capIdx * (L + 1) + L, "R3 capture cycle position", c,
              2 + L + capIdx * (L + 1) + L);
        check(chain == stimA[capIdx], "R4 chain holds stimulus at capture", chain, stimA[capIdx]);
        check(piVec == piA[capIdx], "R5 primary inputs at capture", piVec, piA[capIdx]);
        if (c - L - 1 >= 0)
          check(memAddr == VW'(capIdx + 1), "R10 next pattern addressed", memAddr, capIdx + 1);
        capIdx++;
      end
      if ((c >= 2 && c <= L + 1) || (c >= FLUSH_LO && c < FLUSH_LO + L)) begin
        if (!(scanEn && chainEn && !scanIn)) quietBad++;
      end
      @(negedge clk);
      c++;
    end
    start = 1'b0;
    check(c == TOTAL, {"R2 session length ", name}, c, TOTAL);
    check(doneCnt == 1 && doneAt == TOTAL - 1, "R2 done only in last cycle", doneAt, TOTAL - 1);
    check(capIdx == N, "R3 capture count", capIdx, N);
    check(quietBad == 0, "R6 zero fill in clear and flush", quietBad, 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    memData = '0;
    // clean pattern set, plus a start pulse while busy
    buildSet(1);
    doReset();
    runSession(1'b1, "clean");
    check(!failFlag, "R6 clean set passes", failFlag, 0);

    // masked-out mismatch
    buildSet(2);
    respA[2][1] = ~respA[2][1];
    maskA[2][1] = 1'b0;
    doReset();
    runSession(1'b0, "masked");
    check(!failFlag, "R7 masked bit ignored", failFlag, 0);

    // two scan mismatches: first one wins and stays
    buildSet(3);
    respA[2][3] = ~respA[2][3];
    respA[3][0] = ~respA[3][0];
    doReset();
    runSession(1'b1, "two errors");
    check(failFlag && failVec == 2, "R8 first failing pattern", {failFlag, failVec}, {1'b1, 3'd2});
    repeat (3) @(negedge clk);
    runSession(1'b0, "second run");
    check(failFlag && failVec == 2, "R8 fail held until reset", {failFlag, failVec}, {1'b1, 3'd2});

    // primary-output mismatch before a later scan mismatch
    buildSet(4);
    poA[1][0] = ~poA[1][0];
    respA[3][2] = ~respA[3][2];
    doReset();
    runSession(1'b0, "po error");
    check(failFlag && failVec == 1, "R5 output mismatch flagged", {failFlag, failVec}, {1'b1, 3'd1});

    // last pattern, last flush bit
    buildSet(5);
    respA[N-1][0] = ~respA[N-1][0];
    doReset();
    runSession(1'b0, "flush error");
    check(failFlag && failVec == VW'(N - 1), "R6 flush compare", {failFlag, failVec}, {1'b1, 3'(N - 1)});

    // first pattern response checked during second shift-in
    buildSet(6);
    respA[0][2] = ~respA[0][2];
    doReset();
    runSession(1'b0, "first pattern error");
    check(failFlag && failVec == 0, "R6 first response compared", {failFlag, failVec}, {1'b1, 3'd0});

    doReset();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule